// File: doc/BRIEF.md
# Four-channel DS1 backplane demultiplexer

This block receives one fast serial backplane line that carries four DS1 channels interleaved bit by bit. It splits that line into four separate DS1 bit streams of 193 bits per frame. The backplane clock runs at eight times the DS1 rate, so each DS1 bit period has eight backplane slots. Slots 0 to 3 carry channels 0 to 3 in ascending order. Slots 4 to 7 carry nothing and are discarded. A second instance of the block serves channels 4 to 7 on another line.

A sync input marks the framing-bit position of every DS1 frame. It is active for one backplane clock, and its active level is set by a configuration input. The upstream equipment aligns the data to the sync, so the bit sampled together with an active sync is the framing bit of channel 0. From that point the block free-runs through the frame.

For each channel the block gives a data bit, a one-clock valid strobe and a frame-start flag that marks the framing bit. If a sync arrives anywhere other than the expected start of a frame, the block re-aligns to it and latches a misalignment flag.

Top module: `ds1_bp_demux`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all outputs go to 0 (`ch_data`, `ch_valid`, `ch_frame_start`, `misalign`).
- R2: After reset, and until the first active sync has been sampled, `ch_valid` and `ch_frame_start` stay all-zero whatever `bp_data` carries.
- R3: With `cfg_sync_low` = 0 a sync is active when `bp_sync` is 1. With `cfg_sync_low` = 1 a sync is active when `bp_sync` is 0.
- R4: The bit sampled with an active sync is the framing bit (bit 0) of channel 0. One clock after that edge, `ch_valid[0]` and `ch_frame_start[0]` are 1.
- R5: Inputs are sampled on the rising edge. The sample in slot k (k = 0..3) appears on `ch_data[k]` one clock later, with `ch_valid` equal to one-hot bit k for exactly that clock.
- R6: Samples in slots 4 to 7 raise no strobe and leave `ch_data` unchanged.
- R7: A frame is 193 DS1 bits of 8 slots each. Without any further sync, `ch_frame_start[k]` is raised again with channel k's bit 0 every 1544 clocks, and only with bit 0.
- R8: A sync at the expected position (slot 0 of bit 0) leaves `misalign` low. A sync at any other position while locked makes that sample channel 0's framing bit and sets `misalign` one clock later.
- R9: `cfg_sync_low` is taken while no sync has yet been seen, or at the last slot of bit 192. A change made while locked therefore has no effect until the next frame begins.
- R10: Once set, `misalign` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Backplane clock (8x the DS1 rate) |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_sync_low | input | 1 | Sync polarity select: 0 = active high, 1 = active low |
| bp_data | input | 1 | Interleaved backplane data |
| bp_sync | input | 1 | Single-frame sync, one clock wide |
| ch_data | output | 4 | Last data bit delivered per channel |
| ch_valid | output | 4 | One-clock strobe per channel when its bit is new |
| ch_frame_start | output | 4 | Set with the strobe of each channel's framing bit |
| misalign | output | 1 | Sticky flag for a sync at an unexpected position |

## Verification
The hardest case to reach from the ports is a polarity change made while the block is locked. The new setting must stay dormant for the rest of the frame and then act exactly at the frame boundary. To reach it, the stimulus locks the block with active-high sync and flips `cfg_sync_low` at bit 100 while holding `bp_sync` low. Under the new setting that low level would count as a sync on every clock. The frame must still finish cleanly, and the next frame must lock to an active-low pulse without raising `misalign`. A misaligned sync is reached by stopping a frame after bit 50 slot 1 and then sending a sync with a fresh frame.

// File: rtl/ds1_bp_pkg.sv
// Package: shared defaults for the DS1 backplane demultiplexer.
// Assumes a backplane clock that is an integer multiple of the DS1 rate.
package ds1_bp_pkg;
    localparam int unsigned DEF_CHANNELS   = 4;
    localparam int unsigned DEF_SLOTS      = 8;
    localparam int unsigned DEF_FRAME_BITS = 193;
endpackage

// File: rtl/ds1_bp_sync_detect.sv
// Sync detector: holds the active sync polarity and flags an active sync.
// The polarity is reloaded from configuration only while the block is idle,
// or on the last slot of a frame, so a change applies from the next frame.
// Assumes cfg_sync_low is quasi-static with respect to clk.
module ds1_bp_sync_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_sync_low,
    input  logic bp_sync,
    input  logic locked,
    input  logic frame_last,
    output logic pol_low,
    output logic sync_hit
);
    logic pol_q;

    // Polarity register: follows config in reset, while idle, or at frame end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q <= cfg_sync_low;
        end else if (!locked || frame_last) begin
            pol_q <= cfg_sync_low;
        end
    end

    // Active-sync decode against the held polarity
    always_comb begin
        sync_hit = pol_q ? !bp_sync : bp_sync;
    end

    assign pol_low = pol_q;
endmodule

// File: rtl/ds1_bp_slot_timer.sv
// Slot timer: tracks slot-within-bit and bit-within-frame positions.
// An active sync forces the current sample to slot 0 of bit 0. The timer
// free-runs once locked, and flags a sync seen at an unexpected position.
// Assumes SLOTS >= 2 and FRAME_BITS >= 2.
module ds1_bp_slot_timer #(
    parameter int unsigned SLOTS      = 8,
    parameter int unsigned FRAME_BITS = 193,
    localparam int unsigned SLOT_W    = $clog2(SLOTS),
    localparam int unsigned BIT_W     = $clog2(FRAME_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_hit,
    output logic              run,
    output logic [SLOT_W-1:0] cur_slot,
    output logic              cur_bit0,
    output logic              frame_last,
    output logic              locked,
    output logic              misalign
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(FRAME_BITS - 1);

    logic [SLOT_W-1:0] slot_q;
    logic [BIT_W-1:0]  bit_q;
    logic [BIT_W-1:0]  cur_bitn;
    logic              locked_q;
    logic              mis_q;
    logic              at_expected;

    // Position of the sample being taken this clock
    always_comb begin
        run         = locked_q || sync_hit;
        cur_slot    = sync_hit ? '0 : slot_q;
        cur_bitn    = sync_hit ? '0 : bit_q;
        cur_bit0    = (cur_bitn == '0);
        frame_last  = run && (cur_slot == LAST_SLOT) && (cur_bitn == LAST_BIT);
        at_expected = (slot_q == '0) && (bit_q == '0);
    end

    // Advance slot and bit counters to the position of the next sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            bit_q  <= '0;
        end else if (run) begin
            if (cur_slot == LAST_SLOT) begin
                slot_q <= '0;
                bit_q  <= (cur_bitn == LAST_BIT) ? '0 : cur_bitn + 1'b1;
            end else begin
                slot_q <= cur_slot + 1'b1;
                bit_q  <= cur_bitn;
            end
        end
    end

    // Lock on first sync, and latch the sticky misalignment flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_q <= 1'b0;
            mis_q    <= 1'b0;
        end else begin
            if (sync_hit) begin
                locked_q <= 1'b1;
            end
            if (sync_hit && locked_q && !at_expected) begin
                mis_q <= 1'b1;
            end
        end
    end

    assign locked   = locked_q;
    assign misalign = mis_q;
endmodule

// File: rtl/ds1_bp_lane.sv
// Channel lane: captures the backplane bit in this lane's slot and raises a
// one-clock valid strobe, with a frame-start flag on the framing bit.
// Data holds its last value between strobes. Assumes IDX < SLOTS.
module ds1_bp_lane #(
    parameter int unsigned SLOTS  = 8,
    parameter int unsigned IDX    = 0,
    localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [SLOT_W-1:0] cur_slot,
    input  logic              cur_bit0,
    input  logic              bp_data,
    output logic              data_o,
    output logic              valid_o,
    output logic              fstart_o
);
    logic mine;

    // Decode whether the current sample belongs to this lane
    always_comb begin
        mine = run && (cur_slot == SLOT_W'(IDX));
    end

    // Capture data and produce the strobes for this lane
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o   <= 1'b0;
            valid_o  <= 1'b0;
            fstart_o <= 1'b0;
        end else begin
            valid_o  <= mine;
            fstart_o <= mine && cur_bit0;
            if (mine) begin
                data_o <= bp_data;
            end
        end
    end
endmodule

// File: rtl/ds1_bp_demux.sv
// Top: four-channel DS1 backplane demultiplexer.
// Splits a bit-interleaved backplane line into N_CH DS1 streams, using a
// single-frame sync of programmable polarity to find the framing bit.
// Assumes the upstream equipment aligns data with the sync pulse.
module ds1_bp_demux #(
    parameter int unsigned N_CH       = ds1_bp_pkg::DEF_CHANNELS,
    parameter int unsigned SLOTS      = ds1_bp_pkg::DEF_SLOTS,
    parameter int unsigned FRAME_BITS = ds1_bp_pkg::DEF_FRAME_BITS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_sync_low,
    input  logic            bp_data,
    input  logic            bp_sync,
    output logic [N_CH-1:0] ch_data,
    output logic [N_CH-1:0] ch_valid,
    output logic [N_CH-1:0] ch_frame_start,
    output logic            misalign
);
    localparam int unsigned SLOT_W = $clog2(SLOTS);

    logic              sync_hit;
    logic              pol_low;
    logic              run;
    logic [SLOT_W-1:0] cur_slot;
    logic              cur_bit0;
    logic              frame_last;
    logic              locked;

    ds1_bp_sync_detect u_sync (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_sync_low (cfg_sync_low),
        .bp_sync      (bp_sync),
        .locked       (locked),
        .frame_last   (frame_last),
        .pol_low      (pol_low),
        .sync_hit     (sync_hit)
    );

    ds1_bp_slot_timer #(
        .SLOTS      (SLOTS),
        .FRAME_BITS (FRAME_BITS)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_hit   (sync_hit),
        .run        (run),
        .cur_slot   (cur_slot),
        .cur_bit0   (cur_bit0),
        .frame_last (frame_last),
        .locked     (locked),
        .misalign   (misalign)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_lane
        ds1_bp_lane #(
            .SLOTS (SLOTS),
            .IDX   (g)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run),
            .cur_slot (cur_slot),
            .cur_bit0 (cur_bit0),
            .bp_data  (bp_data),
            .data_o   (ch_data[g]),
            .valid_o  (ch_valid[g]),
            .fstart_o (ch_frame_start[g])
        );
    end
endmodule

// File: rtl/ds1_bp_demux_chk.sv
// Checker: temporal properties of the demultiplexer, bound to the top.
module ds1_bp_demux_chk #(
    parameter int unsigned N_CH = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sync_hit,
    input logic            locked,
    input logic            frame_last,
    input logic            pol_low,
    input logic [N_CH-1:0] ch_valid,
    input logic [N_CH-1:0] ch_frame_start,
    input logic            misalign
);
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && !sync_hit) |=> (ch_valid == '0));

    p_sync_is_fbit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sync_hit |=> (ch_valid[0] && ch_frame_start[0]));

    p_one_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_valid));

    p_fstart_in_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((ch_frame_start & ~ch_valid) == '0));

    for (genvar k = 0; k + 1 < N_CH; k++) begin : g_order
        p_slot_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ch_valid[k] |=> (ch_valid[k+1] || ch_valid[0]));
    end

    p_mis_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(misalign) |-> $past(sync_hit));

    p_pol_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !frame_last) |=> $stable(pol_low));

    p_mis_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |=> misalign);
endmodule

bind ds1_bp_demux ds1_bp_demux_chk #(.N_CH(N_CH)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .sync_hit       (sync_hit),
    .locked         (locked),
    .frame_last     (frame_last),
    .pol_low        (pol_low),
    .ch_valid       (ch_valid),
    .ch_frame_start (ch_frame_start),
    .misalign       (misalign)
);

// File: tb/ds1_bp_demux_tb_top.sv
module ds1_bp_demux_tb_top;
    localparam int N = 4;
    localparam int NS = 8;
    localparam int FB = 193;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_sync_low = 1'b0;
    logic bp_data = 1'b0;
    logic bp_sync = 1'b0;
    logic [N-1:0] ch_data, ch_valid, ch_frame_start;
    logic misalign;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ds1_bp_demux dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_sync_low(cfg_sync_low),
        .bp_data(bp_data), .bp_sync(bp_sync), .ch_data(ch_data),
        .ch_valid(ch_valid), .ch_frame_start(ch_frame_start), .misalign(misalign)
    );

    function automatic logic pat(int c, int b, int seed);
        return logic'(((b * 37 + c * 11 + seed) % 7) < 3);
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One backplane clock: drive at the falling edge, settle after the rising edge
    task automatic step(input logic d, input logic s);
        @(negedge clk);
        bp_data = d;
        bp_sync = s;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic pol);
        cfg_sync_low = pol;
        rst_n = 1'b0;
        repeat (3) step(1'b1, pol);
        rst_n = 1'b1;
    endtask

    // Drive bits b0..b1-1 of a frame and check every slot; one check per span
    task automatic run_span(input int b0, input int b1, input logic pol, input logic sync_first,
                            input int sw_bit, input int seed, input string req);
        logic bad = 1'b0;
        for (int b = b0; b < b1; b++) begin
            for (int s = 0; s < NS; s++) begin
                logic d, sy;
                logic [N-1:0] ev, efs, ed;
                d  = (s < N) ? pat(s, b, seed) : ~pat(s - N, b, seed);
                sy = (sync_first && b == b0 && s == 0) ? ~pol : pol;
                if (b == sw_bit && s == 0) cfg_sync_low = ~cfg_sync_low;
                step(d, sy);
                ev  = (s < N) ? N'(1 << s) : '0;
                efs = (s < N && b == 0) ? N'(1 << s) : '0;
                for (int c = 0; c < N; c++) ed[c] = pat(c, b, seed);
                if (!bad && (ch_valid !== ev || ch_frame_start !== efs ||
                    (s < N && ch_data[s] !== ed[s]) || (s >= N && ch_data !== ed))) begin
                    bad = 1'b1;
                    $display("FAIL %s: bit %0d slot %0d actual v=%b fs=%b d=%b expected v=%b fs=%b d=%b",
                             req, b, s, ch_valid, ch_frame_start, ch_data, ev, efs, ed);
                end
            end
        end
        checks++;
        if (bad) errors++;
    endtask

    task automatic t_reset;
        do_reset(1'b0);
        rst_n = 1'b0;
        step(1'b1, 1'b1);
        chk(ch_valid == '0 && ch_frame_start == '0 && ch_data == '0 && !misalign,
            "R1 outputs in reset", {ch_valid, ch_frame_start, ch_data, misalign}, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_idle;
        logic seen = 1'b0;
        do_reset(1'b0);
        for (int i = 0; i < 120; i++) begin
            step(pat(0, i, 5), 1'b0);
            if (ch_valid != '0 || ch_frame_start != '0) seen = 1'b1;
        end
        chk(!seen, "R2 no strobe before first sync", seen, 0);
    endtask

    task automatic t_basic;
        run_span(0, FB, 1'b0, 1'b1, -1, 3, "R4 R5 R6 first frame");
        chk(!misalign, "R8 first sync sets no flag", misalign, 0);
    endtask

    task automatic t_freerun;
        run_span(0, FB, 1'b0, 1'b0, -1, 9, "R7 free-running frame");
        run_span(0, FB, 1'b0, 1'b1, -1, 4, "R7 frame with expected sync");
        chk(!misalign, "R8 expected sync sets no flag", misalign, 0);
    endtask

    task automatic t_misalign;
        run_span(0, 50, 1'b0, 1'b0, -1, 2, "R7 partial frame");
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        run_span(0, FB, 1'b0, 1'b1, -1, 6, "R8 realigned frame");
        chk(misalign, "R8 misaligned sync flagged", misalign, 1);
        run_span(0, FB, 1'b0, 1'b1, -1, 8, "R10 frame after misalign");
        chk(misalign, "R10 flag stays set", misalign, 1);
        do_reset(1'b0);
        chk(!misalign, "R1 R10 reset clears flag", misalign, 0);
    endtask

    task automatic t_low_pol;
        logic seen = 1'b0;
        do_reset(1'b1);
        for (int i = 0; i < 40; i++) begin
            step(1'b1, 1'b1);
            if (ch_valid != '0) seen = 1'b1;
        end
        chk(!seen, "R3 high level inactive when low-active", seen, 0);
        run_span(0, FB, 1'b1, 1'b1, -1, 11, "R3 low-active frame");
        run_span(0, FB, 1'b1, 1'b1, -1, 12, "R3 low-active second frame");
        chk(!misalign, "R3 low-active sync aligned", misalign, 0);
    endtask

    task automatic t_pol_change;
        do_reset(1'b0);
        run_span(0, FB, 1'b0, 1'b1, -1, 1, "R9 lock active-high");
        run_span(0, FB, 1'b0, 1'b1, 100, 7, "R9 change mid-frame held off");
        chk(!misalign, "R9 no false sync after change", misalign, 0);
        run_span(0, FB, 1'b1, 1'b1, -1, 13, "R9 new polarity at next frame");
        chk(!misalign, "R9 new polarity aligned", misalign, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_idle();
        t_basic();
        t_freerun();
        t_misalign();
        t_low_pol();
        t_pol_change();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule